// File: doc/BRIEF.md
# Angular Intra Reference Array Builder

This block keeps the reconstructed neighbour pixels of one 8x8 region of a 32x32 coding unit in a 42-entry register window. From that window it builds the one-dimensional reference array that the angular prediction lanes index into. A region-start pulse opens a new load. The neighbour stream then arrives as three pixels per accepted beat, and after sixteen beats the builder raises `ready_o`. Each region of the coding unit is loaded in turn, and every region start throws away the readiness of the previous one.

While ready, a request carries a mode number, a signed prediction angle and an inverse-angle value. One cycle later the builder presents a 25-entry array. Entries 4 to 24 hold the main side, taken from the above row for modes 18 and up and from the left column otherwise. Entries 0 to 3 are the reserved slots for indices -4 to -1. For a negative angle these slots are filled with pixels projected from the opposite side. For an angle of zero or more they hold the main-side corner.

The controller is a three-state machine. `ST_IDLE` is the state after reset, where nothing is loaded; a region start moves it to `ST_LOAD`. `ST_LOAD` counts accepted beats; on the sixteenth beat it moves to `ST_READY`, and a region start restarts the count in `ST_LOAD`. `ST_READY` serves requests; a region start moves it back to `ST_LOAD`.

Top module: `ref_array_builder`

## Requirements
- R1: While reset is applied, and after it is released, `ready_o` and `ref_valid_o` are low and `ref_o` is all zeros.
- R2: A cycle with `region_start_i` high makes `ready_o` low on the next cycle. A `load_valid_i` beat in idle or ready state leaves the window unchanged and causes no change at the outputs.
- R3: Beat b (0 to 15, counted from the region start) writes lane l (bits l*8+7 down to l*8 of `load_pix_i`) into window position 3*b+l. Positions 0 to 20 form the above side, with position 0 the corner and position i the i-th pixel above. Positions 21 to 41 form the left side, with position 21 the corner and position 21+i the i-th pixel to the left. Lanes that land on positions 42 and above are discarded.
- R4: `ready_o` rises on the cycle after the sixteenth accepted beat, and cycles without `load_valid_i` are not counted. It then stays high until the next region start.
- R5: A request is taken only when `ready_o` is high and `region_start_i` is low in the same cycle. A request taken in a cycle drives `ref_valid_o` high for exactly the next cycle. If a region start and a request arrive together, the region start wins and the request is dropped.
- R6: Entry 4+i of `ref_o` (bits (4+i)*8+7 down to (4+i)*8), for i from 0 to 20, holds above-side position i when the mode is 18 or more. It holds left-side position i when the mode is below 18.
- R7: For a negative angle, reserved entry 4-k (k = 1 to 4) holds opposite-side position ((128 - k*inv) >>> 8), clamped to the range 0 to 20. The opposite side is the left side for modes of 18 or more and the above side otherwise.
- R8: For an angle of zero or more, all four reserved entries equal the main-side corner (entry 4).
- R9: `ref_o` keeps its value in every cycle that follows no taken request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| region_start_i | input | 1 | Starts loading a new 8x8 region |
| load_valid_i | input | 1 | Load beat strobe |
| load_pix_i | input | 24 | Three 8-bit pixels per beat, lane 0 in the low byte |
| req_valid_i | input | 1 | Reference array request |
| req_mode_i | input | 6 | Angular mode number |
| req_angle_i | input | 6 | Signed prediction angle |
| req_inv_i | input | 13 | Signed inverse angle |
| ready_o | output | 1 | Window loaded, requests accepted |
| ref_valid_o | output | 1 | `ref_o` updated this cycle |
| ref_o | output | 200 | 25 entries of 8 bits, entry 0 at the low byte, entry n is index n-4 |

## Verification
A new region start and a reference request can land in the same cycle, because the prediction side may ask for one more array just as the loader moves on to the next region. The bench drives both strobes on one clock edge while the window is ready. The scoreboard receives no expected item for that request, so any `ref_valid_o` that follows is flagged as unexpected. The bench also checks that `ready_o` falls. The next array is then compared against a freshly loaded region, so a request that had slipped through against stale pixels would show up as a mismatch.

// File: rtl/ref_array_pkg.sv
package ref_array_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_READY
    } refb_state_e;

    localparam int unsigned DEF_PIX_W      = 8;
    localparam int unsigned DEF_SIDE_N     = 21;
    localparam int unsigned DEF_RES_N      = 4;
    localparam int unsigned DEF_PPB        = 3;
    localparam int unsigned DEF_LOAD_BEATS = 16;
    localparam int unsigned DEF_MODE_SPLIT = 18;

endpackage

// File: rtl/refb_ctrl.sv
module refb_ctrl
    import ref_array_pkg::*;
#(
    parameter int unsigned LOAD_BEATS = DEF_LOAD_BEATS,
    localparam int unsigned BEAT_W    = $clog2(LOAD_BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              region_start_i,
    input  logic              load_valid_i,
    input  logic              req_valid_i,
    output logic              ready_o,
    output logic              load_en_o,
    output logic              req_take_o,
    output logic [BEAT_W-1:0] beat_o
);

    refb_state_e      state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic              last_beat;

    assign last_beat = (beat_q == BEAT_W'(LOAD_BEATS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // next state and beat count
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (region_start_i) begin
                    state_d = ST_LOAD;
                    beat_d  = '0;
                end
            end
            ST_LOAD: begin
                if (region_start_i) begin
                    state_d = ST_LOAD;
                    beat_d  = '0;
                end else if (load_valid_i) begin
                    if (last_beat) begin
                        state_d = ST_READY;
                        beat_d  = '0;
                    end else begin
                        beat_d = beat_q + BEAT_W'(1);
                    end
                end
            end
            ST_READY: begin
                if (region_start_i) begin
                    state_d = ST_LOAD;
                    beat_d  = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                beat_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        ready_o    = 1'b0;
        load_en_o  = 1'b0;
        req_take_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: load_en_o = load_valid_i && !region_start_i;
            ST_READY: begin
                ready_o    = 1'b1;
                req_take_o = req_valid_i && !region_start_i;
            end
            default: ;
        endcase
    end

    assign beat_o = beat_q;

endmodule

// File: rtl/refb_window.sv
module refb_window
    import ref_array_pkg::*;
#(
    parameter int unsigned PIX_W      = DEF_PIX_W,
    parameter int unsigned SIDE_N     = DEF_SIDE_N,
    parameter int unsigned PPB        = DEF_PPB,
    parameter int unsigned LOAD_BEATS = DEF_LOAD_BEATS,
    localparam int unsigned BEAT_W    = $clog2(LOAD_BEATS),
    localparam int unsigned WIN_N     = 2 * SIDE_N
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_en_i,
    input  logic [BEAT_W-1:0]             beat_i,
    input  logic [PPB*PIX_W-1:0]          load_pix_i,
    output logic [SIDE_N-1:0][PIX_W-1:0]  above_o,
    output logic [SIDE_N-1:0][PIX_W-1:0]  left_o
);

    logic [PPB-1:0][PIX_W-1:0] lane_pix;
    logic [WIN_N-1:0][PIX_W-1:0] win_q;

    for (genvar l = 0; l < PPB; l++) begin : g_lane
        assign lane_pix[l] = load_pix_i[l*PIX_W +: PIX_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (load_en_i) begin
            for (int r = 0; r < int'(WIN_N); r++) begin
                if (beat_i == BEAT_W'(r / int'(PPB))) begin
                    win_q[r] <= lane_pix[r % int'(PPB)];
                end
            end
        end
    end

    assign above_o = win_q[SIDE_N-1:0];
    assign left_o  = win_q[WIN_N-1:SIDE_N];

endmodule

// File: rtl/refb_assemble.sv
module refb_assemble
    import ref_array_pkg::*;
#(
    parameter int unsigned PIX_W      = DEF_PIX_W,
    parameter int unsigned SIDE_N     = DEF_SIDE_N,
    parameter int unsigned RES_N      = DEF_RES_N,
    parameter int unsigned MODE_SPLIT = DEF_MODE_SPLIT,
    parameter int unsigned MODE_W     = 6,
    parameter int unsigned ANG_W      = 6,
    parameter int unsigned INV_W      = 13,
    localparam int unsigned REF_N     = SIDE_N + RES_N,
    localparam int unsigned IDX_W     = $clog2(SIDE_N)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           take_i,
    input  logic [MODE_W-1:0]              mode_i,
    input  logic signed [ANG_W-1:0]        angle_i,
    input  logic signed [INV_W-1:0]        inv_i,
    input  logic [SIDE_N-1:0][PIX_W-1:0]   above_i,
    input  logic [SIDE_N-1:0][PIX_W-1:0]   left_i,
    output logic                           valid_o,
    output logic [REF_N*PIX_W-1:0]         ref_o
);

    // projected position on the opposite side for reserved slot -k
    function automatic logic [IDX_W-1:0] proj_idx(input int k, input logic signed [INV_W-1:0] inv);
        int t;
        t = 128 - k * int'(inv);
        t = t >>> 8;
        if (t < 0) t = 0;
        if (t > int'(SIDE_N) - 1) t = int'(SIDE_N) - 1;
        return IDX_W'(t);
    endfunction

    logic                            use_above;
    logic                            neg_angle;
    logic [SIDE_N-1:0][PIX_W-1:0]    main_side;
    logic [SIDE_N-1:0][PIX_W-1:0]    other_side;
    logic [REF_N-1:0][PIX_W-1:0]     ref_d;
    logic [REF_N*PIX_W-1:0]          ref_q;
    logic                            valid_q;

    assign use_above  = (mode_i >= MODE_W'(MODE_SPLIT));
    assign neg_angle  = angle_i[ANG_W-1];
    assign main_side  = use_above ? above_i : left_i;
    assign other_side = use_above ? left_i  : above_i;

    for (genvar i = 0; i < SIDE_N; i++) begin : g_main
        assign ref_d[RES_N + i] = main_side[i];
    end

    for (genvar k = 1; k <= RES_N; k++) begin : g_res
        logic [IDX_W-1:0] idx;
        assign idx = proj_idx(k, inv_i);
        assign ref_d[RES_N - k] = neg_angle ? other_side[idx] : main_side[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ref_q   <= '0;
        end else begin
            valid_q <= take_i;
            if (take_i) begin
                ref_q <= ref_d;
            end
        end
    end

    assign valid_o = valid_q;
    assign ref_o   = ref_q;

endmodule

// File: rtl/ref_array_builder.sv
module ref_array_builder
    import ref_array_pkg::*;
#(
    parameter int unsigned PIX_W      = DEF_PIX_W,
    parameter int unsigned SIDE_N     = DEF_SIDE_N,
    parameter int unsigned RES_N      = DEF_RES_N,
    parameter int unsigned PPB        = DEF_PPB,
    parameter int unsigned LOAD_BEATS = DEF_LOAD_BEATS,
    parameter int unsigned MODE_SPLIT = DEF_MODE_SPLIT,
    parameter int unsigned MODE_W     = 6,
    parameter int unsigned ANG_W      = 6,
    parameter int unsigned INV_W      = 13,
    localparam int unsigned REF_N     = SIDE_N + RES_N,
    localparam int unsigned BEAT_W    = $clog2(LOAD_BEATS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     region_start_i,
    input  logic                     load_valid_i,
    input  logic [PPB*PIX_W-1:0]     load_pix_i,
    input  logic                     req_valid_i,
    input  logic [MODE_W-1:0]        req_mode_i,
    input  logic signed [ANG_W-1:0]  req_angle_i,
    input  logic signed [INV_W-1:0]  req_inv_i,
    output logic                     ready_o,
    output logic                     ref_valid_o,
    output logic [REF_N*PIX_W-1:0]   ref_o
);

    logic                          load_en;
    logic                          req_take;
    logic [BEAT_W-1:0]             beat;
    logic [SIDE_N-1:0][PIX_W-1:0]  above_side;
    logic [SIDE_N-1:0][PIX_W-1:0]  left_side;

    refb_ctrl #(
        .LOAD_BEATS (LOAD_BEATS)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .region_start_i (region_start_i),
        .load_valid_i   (load_valid_i),
        .req_valid_i    (req_valid_i),
        .ready_o        (ready_o),
        .load_en_o      (load_en),
        .req_take_o     (req_take),
        .beat_o         (beat)
    );

    refb_window #(
        .PIX_W      (PIX_W),
        .SIDE_N     (SIDE_N),
        .PPB        (PPB),
        .LOAD_BEATS (LOAD_BEATS)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en_i  (load_en),
        .beat_i     (beat),
        .load_pix_i (load_pix_i),
        .above_o    (above_side),
        .left_o     (left_side)
    );

    refb_assemble #(
        .PIX_W      (PIX_W),
        .SIDE_N     (SIDE_N),
        .RES_N      (RES_N),
        .MODE_SPLIT (MODE_SPLIT),
        .MODE_W     (MODE_W),
        .ANG_W      (ANG_W),
        .INV_W      (INV_W)
    ) u_assemble (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (req_take),
        .mode_i  (req_mode_i),
        .angle_i (req_angle_i),
        .inv_i   (req_inv_i),
        .above_i (above_side),
        .left_i  (left_side),
        .valid_o (ref_valid_o),
        .ref_o   (ref_o)
    );

endmodule

// File: rtl/ref_array_builder_chk.sv
module ref_array_builder_chk #(
    parameter int unsigned PIX_W      = 8,
    parameter int unsigned RES_N      = 4,
    parameter int unsigned REF_N      = 25,
    parameter int unsigned ANG_W      = 6,
    parameter int unsigned LOAD_BEATS = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    region_start_i,
    input logic                    load_valid_i,
    input logic                    req_valid_i,
    input logic [ANG_W-1:0]        req_angle_i,
    input logic                    ready_o,
    input logic                    ref_valid_o,
    input logic [REF_N*PIX_W-1:0]  ref_o
);

    int unsigned beats_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_seen <= 0;
        end else if (region_start_i) begin
            beats_seen <= 0;
        end else if (load_valid_i && !ready_o && beats_seen < LOAD_BEATS + 1) begin
            beats_seen <= beats_seen + 1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !ready_o && !ref_valid_o); // R1

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        region_start_i |=> !ready_o); // R2

    AST_READY_AFTER_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> beats_seen == LOAD_BEATS); // R4

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && !region_start_i |=> ready_o); // R4

    AST_VALID_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid_o |-> $past(ready_o && req_valid_i && !region_start_i)); // R5

    AST_TAKE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && req_valid_i && !region_start_i |=> ref_valid_o); // R5

    AST_RESERVED_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid_o && !$past(req_angle_i[ANG_W-1]) |->
            ref_o[RES_N*PIX_W-1:0] == {RES_N{ref_o[RES_N*PIX_W +: PIX_W]}}); // R8

    AST_ARRAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid_o |-> $stable(ref_o)); // R9

endmodule

bind ref_array_builder ref_array_builder_chk #(
    .PIX_W      (PIX_W),
    .RES_N      (RES_N),
    .REF_N      (REF_N),
    .ANG_W      (ANG_W),
    .LOAD_BEATS (LOAD_BEATS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .region_start_i (region_start_i),
    .load_valid_i   (load_valid_i),
    .req_valid_i    (req_valid_i),
    .req_angle_i    (req_angle_i),
    .ready_o        (ready_o),
    .ref_valid_o    (ref_valid_o),
    .ref_o          (ref_o)
);

// File: tb/ref_array_builder_tb.sv
`timescale 1ns/1ps
module ref_array_builder_tb;

    localparam int REF_BITS = 200;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                region_start_i = 1'b0;
    logic                load_valid_i = 1'b0;
    logic [23:0]         load_pix_i = '0;
    logic                req_valid_i = 1'b0;
    logic [5:0]          req_mode_i = '0;
    logic signed [5:0]   req_angle_i = '0;
    logic signed [12:0]  req_inv_i = '0;
    logic                ready_o;
    logic                ref_valid_o;
    logic [REF_BITS-1:0] ref_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int model [42];
    logic [REF_BITS-1:0] exp_q [$];
    string               tag_q [$];
    logic [REF_BITS-1:0] last_exp = '0;

    always #2.5 clk = ~clk;

    ref_array_builder u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .region_start_i (region_start_i),
        .load_valid_i   (load_valid_i),
        .load_pix_i     (load_pix_i),
        .req_valid_i    (req_valid_i),
        .req_mode_i     (req_mode_i),
        .req_angle_i    (req_angle_i),
        .req_inv_i      (req_inv_i),
        .ready_o        (ready_o),
        .ref_valid_o    (ref_valid_o),
        .ref_o          (ref_o)
    );

    function automatic int pat(int seed, int i);
        return (i * 11 + seed * 37 + 5) & 255;
    endfunction

    // expected array from the requirements: main side R6, reserved R7/R8
    function automatic logic [REF_BITS-1:0] exp_ref(int mode, int angle, int inv);
        logic [REF_BITS-1:0] r;
        int mb, ob, idx;
        mb = (mode >= 18) ? 0 : 21;
        ob = (mode >= 18) ? 21 : 0;
        for (int i = 0; i < 21; i++) r[(4+i)*8 +: 8] = 8'(model[mb+i]);
        for (int k = 1; k <= 4; k++) begin
            if (angle < 0) begin
                idx = (128 - k * inv) >>> 8;
                if (idx < 0) idx = 0;
                if (idx > 20) idx = 20;
                r[(4-k)*8 +: 8] = 8'(model[ob+idx]);
            end else begin
                r[(4-k)*8 +: 8] = 8'(model[mb]);
            end
        end
        return r;
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // monitor: pops expected arrays as the design produces them
    always @(negedge clk) begin
        if (rst_n && !done && ref_valid_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected ref_valid_o actual=1 expected=0");
            end else begin
                logic [REF_BITS-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (ref_o !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, ref_o, e);
                end
            end
        end
    end

    // R3 beat placement; a gap cycle mid-load exercises R4
    task automatic load_region(int seed);
        @(negedge clk);
        region_start_i = 1'b1;
        @(negedge clk);
        region_start_i = 1'b0;
        check_bit("R2 ready low after region start", ready_o, 1'b0);
        for (int b = 0; b < 16; b++) begin
            if (b == 8) begin
                load_valid_i = 1'b0;
                @(negedge clk);
            end
            if (b == 15) check_bit("R4 ready low before 16th beat", ready_o, 1'b0);
            load_valid_i = 1'b1;
            for (int l = 0; l < 3; l++) begin
                load_pix_i[l*8 +: 8] = 8'(pat(seed, b*3+l));
                if (b*3+l < 42) model[b*3+l] = pat(seed, b*3+l);
            end
            @(negedge clk);
        end
        load_valid_i = 1'b0;
        check_bit("R4 ready after 16th beat", ready_o, 1'b1);
    endtask

    task automatic stray_beats(int seed, int n);
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            load_valid_i = 1'b1;
            for (int l = 0; l < 3; l++) load_pix_i[l*8 +: 8] = 8'(pat(seed, b*3+l+1));
        end
        @(negedge clk);
        load_valid_i = 1'b0;
    endtask

    // driver: pushes the expected array, then issues the request
    task automatic do_req(int mode, int angle, int inv, string tag);
        @(negedge clk);
        last_exp = exp_ref(mode, angle, inv);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
        req_valid_i = 1'b1;
        req_mode_i  = 6'(mode);
        req_angle_i = 6'(angle);
        req_inv_i   = 13'(inv);
        @(negedge clk);
        req_valid_i = 1'b0;
        check_bit({tag, " valid pulse"}, ref_valid_o, 1'b1);
        @(negedge clk);
        check_bit("R5 valid lasts one cycle", ref_valid_o, 1'b0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_bit("R1 ready in reset", ready_o, 1'b0);
        check_bit("R1 valid in reset", ref_valid_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 ready after reset", ready_o, 1'b0);
        checks++;
        if (ref_o !== '0) begin
            errors++;
            $display("FAIL R1 ref_o actual=%h expected=0", ref_o);
        end

        // R2: beats in idle are ignored
        stray_beats(9, 16);
        check_bit("R2 idle beats ignored", ready_o, 1'b0);

        load_region(1);
        do_req(26, 0, 0, "R6 R8 above main, zero angle");
        do_req(10, 0, 0, "R6 R8 left main, zero angle");
        do_req(30, 13, 0, "R8 positive angle");
        do_req(18, -32, -256, "R7 above main, steep negative");
        do_req(17, -26, -315, "R7 left main, negative");
        do_req(11, -2, -4096, "R7 clamped projection");
        do_req(24, -9, -910, "R7 mid negative");

        // R2: beats while ready do not touch the window
        stray_beats(5, 6);
        check_bit("R2 ready kept after stray beats", ready_o, 1'b1);
        do_req(20, -21, -390, "R2 window unchanged after stray beats");

        // R9: output holds without requests
        repeat (4) @(negedge clk);
        checks++;
        if (ref_o !== last_exp) begin
            errors++;
            $display("FAIL R9 hold actual=%h expected=%h", ref_o, last_exp);
        end

        // R5: region start and request in the same cycle
        @(negedge clk);
        region_start_i = 1'b1;
        req_valid_i    = 1'b1;
        req_mode_i     = 6'd26;
        req_angle_i    = '0;
        @(negedge clk);
        region_start_i = 1'b0;
        req_valid_i    = 1'b0;
        check_bit("R5 collision dropped", ref_valid_o, 1'b0);
        check_bit("R2 ready low after collision", ready_o, 1'b0);

        load_region(2);
        do_req(34, 0, 0, "R3 R6 new region above");
        do_req(2, 0, 0, "R3 R6 new region left");
        do_req(22, -5, -1638, "R7 new region negative");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5 missing outputs actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule